// File: doc/BRIEF.md
# Paired-Byte Event Serial Transmitter

This block sits at the output of a smart-card line sniffer. It turns each captured event, either a character seen on the card I/O line or a change on the card reset line, into one 16-bit word. It sends that word to a host-side USB serial bridge as two asynchronous bytes. The two bytes always leave as a single 20-bit shift with no idle time between them. The host never sees a lone byte, so after a long pause it can drop any half-received pair and get back in step. Nothing comes back from the host, so there is no receive path.

The sniffer gives the event fields and a one-cycle valid strobe. The block packs the fields itself, which keeps the word layout in one place. One message can wait in a holding slot while the previous frame is still shifting. When that slot is emptied, the next frame starts right after the stop bit of the current one. A strobe that arrives while the slot is full is lost, and a sticky flag records the loss. With a 48 MHz system clock and the default divide-by-16, the line runs at 3 Mbit/s.

Top module: `evpair_uart_tx`

## Requirements
- R1: After reset `ser_o` is 1, `ev_ready` is 1 and `ovf_o` is 0.
- R2: Each accepted message produces exactly 20 line bits, in this order: start 0, eight data bits least significant first, stop 1, then start 0, eight data bits, stop 1. There is no idle bit inside the 20. Whenever no frame is in progress, `ser_o` is 1.
- R3: Each line bit lasts exactly CLK_DIV clock cycles. `ser_o` changes only on a bit boundary. The default CLK_DIV is 16, which gives 3 Mbit/s from 48 MHz.
- R4: The first byte on the line is message bits [7:0] and the second byte is message bits [15:8].
- R5: A character event (`ev_is_reset`=0) is packed as follows: bits [7:0] hold `ev_char`, bit 8 holds `ev_parity`, bit 9 holds `ev_errsig`, bit 10 holds `ev_rate_act`, bits 11 to 13 are 0, bit 14 is 1 whatever `ev_rst_level` is, and bit 15 is 0.
- R6: A reset event (`ev_is_reset`=1) is packed with bit 15 = 1 and bit 14 = `ev_rst_level`. All other bits are 0, even when the character and flag inputs are non-zero.
- R7: `ev_ready` is 1 exactly when the holding slot is empty. A strobe with `ev_ready`=1 is accepted on that clock edge. If the line is idle, its start bit appears on `ser_o` one clock edge later.
- R8: A message accepted while a frame is shifting waits in the slot. Its start bit follows the previous stop bit with no gap, and every accepted message is sent once, in the order it was accepted.
- R9: A strobe with `ev_ready`=0 is dropped and never reaches the line. It sets `ovf_o`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | One-cycle strobe: an event is present on the field inputs |
| ev_ready | output | 1 | Holding slot empty; a strobe is accepted this cycle |
| ev_is_reset | input | 1 | 1 for a reset-line event, 0 for a character event |
| ev_rst_level | input | 1 | New reset-line level (reset events only) |
| ev_char | input | 8 | Captured character bits, passed on unaltered |
| ev_parity | input | 1 | Received parity bit |
| ev_errsig | input | 1 | Error signal seen after the character |
| ev_rate_act | input | 1 | The rate-switch logic acted on this character |
| ser_o | output | 1 | Serial line to the host bridge, idles high |
| ovf_o | output | 1 | Sticky flag: a strobe was lost |

## Verification
The bench builds the block with CLK_DIV = 5. This value is odd and not a power of two, so an off-by-one in the bit counter or a wrap that only works at 16 shows up as a bit of the wrong length. It also keeps each frame at 100 cycles, which leaves room to cover back-to-back frames, slot refill during a shift and a dropped strobe in a short run. A behavioural model predicts the line, the ready signal and the overflow flag on every cycle. A separate line decoder rebuilds each word and checks the framing.

// File: rtl/evpair_pkg.sv
package evpair_pkg;
   localparam int BYTE_W     = 8;
   localparam int NUM_BYTES  = 2;
   localparam int MSG_W      = BYTE_W * NUM_BYTES;
   localparam int SLOT_W     = BYTE_W + 2;
   localparam int FRAME_BITS = SLOT_W * NUM_BYTES;

   localparam int POS_PAR  = 8;
   localparam int POS_ERR  = 9;
   localparam int POS_RATE = 10;
   localparam int POS_LVL  = 14;
   localparam int POS_KIND = 15;

   typedef logic [MSG_W-1:0] msg_t;

   function automatic msg_t pack_event(input logic is_rst, input logic lvl,
                                       input logic [BYTE_W-1:0] ch,
                                       input logic par, input logic err,
                                       input logic rate);
      msg_t m;
      m = '0;
      m[POS_KIND] = is_rst;
      if (is_rst) begin
         m[POS_LVL] = lvl;
      end else begin
         m[BYTE_W-1:0] = ch;
         m[POS_PAR]    = par;
         m[POS_ERR]    = err;
         m[POS_RATE]   = rate;
         m[POS_LVL]    = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/evpair_baud.sv
module evpair_baud #(
   parameter int CLK_DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);
   localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_DIV - 1);

   generate
      if (CLK_DIV < 2) begin : g_bad_div
         $error("evpair_baud: CLK_DIV must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   assign tick = run && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart || !run || tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !restart |=> !tick);
endmodule

// File: rtl/evpair_hold.sv
module evpair_hold
   import evpair_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic push_valid,
   input  msg_t push_data,
   output logic push_ready,
   input  logic pop,
   output logic full,
   output msg_t data,
   output logic ovf
);
   assign push_ready = !full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
         ovf  <= 1'b0;
      end else begin
         if (push_valid && !full) begin
            full <= 1'b1;
            data <= push_data;
         end else if (pop) begin
            full <= 1'b0;
         end
         if (push_valid && full) begin
            ovf <= 1'b1;
         end
      end
   end

   assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   assert_drop_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      push_valid && !push_ready |=> ovf);
   assert_slot_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      full && !pop |=> full && $stable(data));
endmodule

// File: rtl/evpair_shift.sv
module evpair_shift
   import evpair_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic have_msg,
   input  msg_t msg,
   input  logic tick,
   output logic take,
   output logic busy,
   output logic ser
);
   localparam int IDX_W = $clog2(FRAME_BITS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
   localparam logic [IDX_W-1:0] STOP0    = IDX_W'(SLOT_W - 1);

   logic [FRAME_BITS-1:0] frame_w;
   logic [FRAME_BITS-1:0] sh;
   logic [IDX_W-1:0]      idx;
   logic                  last;

   for (genvar b = 0; b < NUM_BYTES; b++) begin : g_slot
      assign frame_w[b*SLOT_W]                = 1'b0;
      assign frame_w[b*SLOT_W+1 +: BYTE_W]    = msg[b*BYTE_W +: BYTE_W];
      assign frame_w[b*SLOT_W+SLOT_W-1]       = 1'b1;
   end

   assign last = busy && tick && (idx == LAST_IDX);
   assign take = have_msg && (!busy || last);
   assign ser  = sh[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '1;
         idx  <= '0;
         busy <= 1'b0;
      end else if (take) begin
         sh   <= frame_w;
         idx  <= '0;
         busy <= 1'b1;
      end else if (last) begin
         sh   <= '1;
         idx  <= '0;
         busy <= 1'b0;
      end else if (busy && tick) begin
         sh   <= {1'b1, sh[FRAME_BITS-1:1]};
         idx  <= idx + 1'b1;
      end
   end

   assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> ser);
   assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !ser);
   assert_mid_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy && idx == STOP0 |-> ser);
   assert_bit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !tick && !take |=> $stable(ser));
endmodule

// File: rtl/evpair_uart_tx.sv
module evpair_uart_tx
   import evpair_pkg::*;
#(
   parameter int CLK_DIV = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ev_valid,
   output logic       ev_ready,
   input  logic       ev_is_reset,
   input  logic       ev_rst_level,
   input  logic [7:0] ev_char,
   input  logic       ev_parity,
   input  logic       ev_errsig,
   input  logic       ev_rate_act,
   output logic       ser_o,
   output logic       ovf_o
);
   msg_t packed_w;
   msg_t slot_data;
   logic slot_full;
   logic take;
   logic busy;
   logic tick;

   assign packed_w = pack_event(ev_is_reset, ev_rst_level, ev_char,
                                ev_parity, ev_errsig, ev_rate_act);

   evpair_hold u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_valid (ev_valid),
      .push_data  (packed_w),
      .push_ready (ev_ready),
      .pop        (take),
      .full       (slot_full),
      .data       (slot_data),
      .ovf        (ovf_o)
   );

   evpair_baud #(.CLK_DIV(CLK_DIV)) u_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .restart (take),
      .tick    (tick)
   );

   evpair_shift u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .have_msg (slot_full),
      .msg      (slot_data),
      .tick     (tick),
      .take     (take),
      .busy     (busy),
      .ser      (ser_o)
   );

   assert_accept_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid && ev_ready && !busy |=> ##1 !ser_o);
endmodule

// File: tb/evpair_uart_tx_tb.sv
module evpair_uart_tx_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int TB_DIV     = 5;
   localparam int NBITS      = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ev_valid = 1'b0;
   logic       ev_is_reset = 1'b0;
   logic       ev_rst_level = 1'b0;
   logic [7:0] ev_char = 8'h00;
   logic       ev_parity = 1'b0;
   logic       ev_errsig = 1'b0;
   logic       ev_rate_act = 1'b0;
   logic       ev_ready;
   logic       ser_o;
   logic       ovf_o;

   int n_cmp  = 0;
   int n_fail = 0;
   int n_rx   = 0;
   int n_acc  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   evpair_uart_tx #(.CLK_DIV(TB_DIV)) dut_i (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
      .ev_is_reset(ev_is_reset), .ev_rst_level(ev_rst_level), .ev_char(ev_char),
      .ev_parity(ev_parity), .ev_errsig(ev_errsig), .ev_rate_act(ev_rate_act),
      .ser_o(ser_o), .ovf_o(ovf_o));

   function automatic logic [15:0] exp_word(input logic is_rst, input logic lvl,
      input logic [7:0] ch, input logic p, input logic e, input logic r);
      if (is_rst) return {1'b1, lvl, 14'b0};            // R6
      return {1'b0, 1'b1, 3'b000, r, e, p, ch};          // R5
   endfunction

   function automatic logic frame_bit(input logic [15:0] w, input int k);
      int pos;
      pos = k % 10;
      if (pos == 0) return 1'b0;
      if (pos == 9) return 1'b1;
      return w[(k / 10) * 8 + pos - 1];
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference model
   logic [15:0] m_hold_q[$];
   logic [15:0] exp_q[$];
   logic [15:0] m_word;
   int  m_bit, m_cnt;
   bit  m_busy, m_ovf;

   always @(posedge clk) begin
      bit acc;
      if (!rst_n) begin
         m_hold_q.delete();
         m_busy = 0; m_ovf = 0; m_bit = 0; m_cnt = 0; m_word = '0;
      end else begin
         acc = ev_valid && (m_hold_q.size() == 0);
         if (ev_valid && m_hold_q.size() != 0) m_ovf = 1;
         if (m_busy) begin
            if (m_cnt == TB_DIV - 1) begin
               m_cnt = 0;
               if (m_bit == NBITS - 1) m_busy = 0;
               else m_bit++;
            end else m_cnt++;
         end
         if (!m_busy && m_hold_q.size() != 0) begin
            m_word = m_hold_q.pop_front();
            m_busy = 1; m_bit = 0; m_cnt = 0;
         end
         if (acc) begin
            logic [15:0] w;
            w = exp_word(ev_is_reset, ev_rst_level, ev_char, ev_parity, ev_errsig, ev_rate_act);
            m_hold_q.push_back(w);
            exp_q.push_back(w);
            n_acc++;
         end
      end
   end

   // Cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         logic m_tx;
         m_tx = m_busy ? frame_bit(m_word, m_bit) : 1'b1;
         check(ser_o === m_tx, "R2 R3 R4 R8 line", ser_o, m_tx);
         check(ev_ready === (m_hold_q.size() == 0), "R7 ready", ev_ready, m_hold_q.size() == 0);
         check(ovf_o === m_ovf, "R9 overflow", ovf_o, m_ovf);
      end
   end

   // Independent line decoder
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && ser_o === 1'b0) begin
            logic [NBITS-1:0] b;
            logic [15:0] got, want;
            b[0] = 1'b0;
            repeat (TB_DIV/2) @(negedge clk);
            check(ser_o === 1'b0, "R2 first start bit mid-sample", ser_o, 0);
            for (int k = 1; k < NBITS; k++) begin
               repeat (TB_DIV) @(negedge clk);
               b[k] = ser_o;
            end
            check(b[10] === 1'b0, "R2 second start bit", b[10], 0);
            check(b[9] === 1'b1 && b[19] === 1'b1, "R2 stop bits", {b[19], b[9]}, 3);
            got = {b[18:11], b[8:1]};
            n_rx++;
            if (exp_q.size() == 0) begin
               check(0, "R9 unexpected frame on line", got, 0);
            end else begin
               want = exp_q.pop_front();
               check(got === want, "R4 R5 R6 decoded word", got, want);
            end
            repeat (TB_DIV - TB_DIV/2 - 1) @(negedge clk);
         end
      end
   end

   task automatic drive(input logic is_rst, input logic lvl, input logic [7:0] ch,
                        input logic p, input logic e, input logic r);
      ev_valid = 1'b1; ev_is_reset = is_rst; ev_rst_level = lvl;
      ev_char = ch; ev_parity = p; ev_errsig = e; ev_rate_act = r;
      @(negedge clk);
      ev_valid = 1'b0;
   endtask

   task automatic send(input logic is_rst, input logic lvl, input logic [7:0] ch,
                       input logic p, input logic e, input logic r);
      @(negedge clk);
      while (!ev_ready) @(negedge clk);
      drive(is_rst, lvl, ch, p, e, r);
   endtask

   task automatic drain();
      repeat (2 * NBITS * TB_DIV + 10) @(negedge clk);
   endtask

   task automatic run_main();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(ser_o === 1'b1, "R1 line idle after reset", ser_o, 1);
      check(ev_ready === 1'b1, "R1 ready after reset", ev_ready, 1);
      check(ovf_o === 1'b0, "R1 overflow clear after reset", ovf_o, 0);

      // R7: start bit one edge after acceptance on idle line
      ev_valid = 1'b1; ev_is_reset = 0; ev_char = 8'hA5; ev_parity = 1;
      ev_errsig = 0; ev_rate_act = 0; ev_rst_level = 0;
      @(negedge clk);
      ev_valid = 1'b0;
      check(ser_o === 1'b1, "R7 no start bit yet", ser_o, 1);
      @(negedge clk);
      check(ser_o === 1'b0, "R7 start bit after one edge", ser_o, 0);
      drain();

      send(1, 1, 8'hFF, 1, 1, 1);   // R6 fields ignored, level 1
      drain();
      send(1, 0, 8'h5A, 1, 0, 1);   // R6 level 0
      drain();
      send(0, 0, 8'h00, 0, 1, 1);   // R5 flags set, level input 0 ignored
      drain();

      // R8 back to back through the holding slot, then R9 drop
      send(0, 1, 8'h3C, 1, 0, 0);
      send(0, 1, 8'hFF, 0, 0, 1);
      check(ev_ready === 1'b0, "R8 slot occupied while shifting", ev_ready, 0);
      drive(0, 1, 8'h81, 1, 1, 1);  // dropped: slot full
      check(ovf_o === 1'b1, "R9 overflow set on drop", ovf_o, 1);
      drain();
      send(0, 0, 8'h7E, 0, 0, 0);
      drain();
      check(ovf_o === 1'b1, "R9 overflow stays set", ovf_o, 1);
      check(exp_q.size() == 0, "R8 every accepted message sent", exp_q.size(), 0);
      check(n_rx == n_acc, "R8 frame count", n_rx, n_acc);
      check(n_acc == 7, "R9 dropped strobe not accepted", n_acc, 7);
   endtask

   initial begin
      fork
         run_main();
         begin
            repeat (100000) @(posedge clk);
            check(0, "watchdog expired", 0, 1);
         end
      join_any
      disable fork;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end
endmodule